// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges five reset causes into one system reset for a microcontroller-class design: a supply-good level from an analog detector, a brown-out request, an active-low external reset pin, a one-cycle watchdog expiry pulse and a one-cycle software reset strobe. The system reset also drives the tristate enable for the general-purpose ports. While reset is active, every register in the chip returns to its initial value. When reset is released, instruction fetch starts at the address given on a constant reset-vector output.

Power-up release happens in two stages. When the supply-good input rises, a fixed initialization interval runs first. A start-up delay follows, and a 2-bit select input chooses its length from four preset lengths. If the supply-good input falls, reset asserts at once without waiting for a clock edge, and any sequence in progress is abandoned. The external pin passes through a synchronizer and holds reset for as long as it stays low, so it can extend reset past the power-up delay. The watchdog, software and brown-out requests each hold reset for at least a minimum number of cycles.

A cold-start flag is set by loss of supply. Software clears it by writing 0. Resets from any other source leave it unchanged.

Top module: `rst_sequencer`

## Requirements
- R1: While `por_ok` is low, `sys_rst` is 1, and it goes to 1 as soon as `por_ok` falls, without waiting for a clock edge.
- R2: `port_hiz` always has the same value as `sys_rst`.
- R3: `rst_vector` is the constant 16'h0000 (parameter `RESET_VEC`).
- R4: After `por_ok` rises, `sys_rst` falls at the rising edge numbered INIT_CYC + L + 1, counting the first edge after the rise as edge 1. L is chosen by `dly_sel`: 2'b00 selects START_LEN0 (4), 2'b01 selects START_LEN1 (8), 2'b10 selects START_LEN2 (16) and 2'b11 selects START_LEN3 (32). INIT_CYC defaults to 8.
- R5: If `por_ok` falls in the middle of a sequence, that sequence is dropped. The next rise of `por_ok` restarts the full count of R4.
- R6: A `wdt_pulse` sampled high at edge E holds `sys_rst` at 1 from edge E through edge E+MIN_PULSE-1 (MIN_PULSE defaults to 6). It is 0 after that if no other source is active.
- R7: A `sw_pulse` sampled high at edge E gives the same reset window as R6.
- R8: `bod_req` is a level. `sys_rst` is 1 from the first edge that samples it high through MIN_PULSE-1 edges after the last edge that samples it high.
- R9: `ext_rst_n` is active low. If the first edge that samples it low is E, `sys_rst` is 1 from edge E+2. If the first edge that samples it high again is F, `sys_rst` is 0 from edge F+2.
- R10: If `ext_rst_n` stays low past the end of the power-up sequence, `sys_rst` stays at 1 until the release given in R9.
- R11: `cold_flag` becomes 1 while `por_ok` is low. Watchdog, software, brown-out and pin resets leave it unchanged.
- R12: When `cold_we` is high with `cold_wdata`=0, `cold_flag` is 0 after that edge. A write with `cold_wdata`=1 leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_ok | input | 1 | Supply-good level from the detector; low means the supply has failed |
| bod_req | input | 1 | Brown-out reset request level, synchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_pulse | input | 1 | Watchdog expiry, one-cycle pulse |
| sw_pulse | input | 1 | Software reset strobe, one-cycle pulse |
| dly_sel | input | 2 | Selects the start-up delay length |
| cold_we | input | 1 | Write strobe for the cold-start flag |
| cold_wdata | input | 1 | Write data for the flag; 0 clears it |
| sys_rst | output | 1 | System reset, active high |
| port_hiz | output | 1 | Tristate enable for the I/O ports |
| cold_flag | output | 1 | Cold-start flag |
| rst_vector | output | 16 | Fetch address after reset |

## Verification
A power-up sequencer stuck in the wrong stage, or counting one step off, shows on `sys_rst` as a release that is too early or too late by whole cycles. The bench checks the exact release edge for three different delay selections, so such a fault shows within at most 41 cycles of the rise. A stretch counter that loads the wrong value moves the end of the watchdog, software or brown-out window, which appears within MIN_PULSE+1 cycles. A synchronizer with the wrong depth moves both edges of a pin-driven reset, and a flag that the wrong source disturbs shows on `cold_flag` one edge after the event.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        SEQ_INIT  = 2'd0,
        SEQ_START = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic por_hold;
        logic ext_hold;
        logic pulse_hold;
    } hold_vec_t;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic int bits_for(input int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/rstseq_power_seq.sv
module rstseq_power_seq
    import rstseq_pkg::*;
#(
    parameter int INIT_CYC   = 8,
    parameter int START_LEN0 = 4,
    parameter int START_LEN1 = 8,
    parameter int START_LEN2 = 16,
    parameter int START_LEN3 = 32,
    parameter int CW         = 6
) (
    input  logic       clk,
    input  logic       por_ok,
    input  logic [1:0] dly_sel,
    output logic       por_hold
);
    localparam logic [CW-1:0] INIT_LAST = CW'(INIT_CYC - 1);

    seq_state_e    state;
    logic [CW-1:0] cnt;
    logic [CW-1:0] start_last;

    always_comb begin
        case (dly_sel)
            2'b00:   start_last = CW'(START_LEN0 - 1);
            2'b01:   start_last = CW'(START_LEN1 - 1);
            2'b10:   start_last = CW'(START_LEN2 - 1);
            default: start_last = CW'(START_LEN3 - 1);
        endcase
    end

    always_ff @(posedge clk or negedge por_ok) begin
        if (!por_ok) begin
            state <= SEQ_INIT;
            cnt   <= '0;
        end else begin
            case (state)
                SEQ_INIT: begin
                    if (cnt == INIT_LAST) begin
                        state <= SEQ_START;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SEQ_START: begin
                    if (cnt == start_last) begin
                        state <= SEQ_RUN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= SEQ_RUN;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign por_hold = (state != SEQ_RUN);

endmodule

// File: rtl/rstseq_pin_sync.sv
module rstseq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_ok,
    input  logic pin_n,
    output logic active
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or negedge por_ok) begin
        if (!por_ok) begin
            sh <= '1;
        end else begin
            sh <= {sh[STAGES-2:0], ~pin_n};
        end
    end

    assign active = sh[STAGES-1];

endmodule

// File: rtl/rstseq_stretch.sv
module rstseq_stretch #(
    parameter int MIN_PULSE = 6,
    parameter int PW        = 3
) (
    input  logic clk,
    input  logic por_ok,
    input  logic req,
    output logic hold
);
    localparam logic [PW-1:0] LOAD_VAL = PW'(MIN_PULSE - 1);

    logic [PW-1:0] remain;

    always_ff @(posedge clk or negedge por_ok) begin
        if (!por_ok) begin
            remain <= '0;
        end else if (req) begin
            remain <= LOAD_VAL;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign hold = req | (remain != '0);

endmodule

// File: rtl/rstseq_cold_flag.sv
module rstseq_cold_flag (
    input  logic clk,
    input  logic por_ok,
    input  logic wr_en,
    input  logic wr_data,
    output logic flag
);
    always_ff @(posedge clk or negedge por_ok) begin
        if (!por_ok) begin
            flag <= 1'b1;
        end else if (wr_en && !wr_data) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
    import rstseq_pkg::*;
#(
    parameter int          INIT_CYC    = 8,
    parameter int          START_LEN0  = 4,
    parameter int          START_LEN1  = 8,
    parameter int          START_LEN2  = 16,
    parameter int          START_LEN3  = 32,
    parameter int          MIN_PULSE   = 6,
    parameter int          SYNC_STAGES = 2,
    parameter int          VEC_W       = 16,
    parameter logic [15:0] RESET_VEC   = 16'h0000
) (
    input  logic             clk,
    input  logic             por_ok,
    input  logic             bod_req,
    input  logic             ext_rst_n,
    input  logic             wdt_pulse,
    input  logic             sw_pulse,
    input  logic [1:0]       dly_sel,
    input  logic             cold_we,
    input  logic             cold_wdata,
    output logic             sys_rst,
    output logic             port_hiz,
    output logic             cold_flag,
    output logic [VEC_W-1:0] rst_vector
);
    localparam int MAX_LEN = max_of4(max_of4(START_LEN0, START_LEN1, START_LEN2, START_LEN3),
                                     INIT_CYC, 1, 1);
    localparam int CW      = bits_for(MAX_LEN);
    localparam int PW      = bits_for(MIN_PULSE);

    hold_vec_t hv;
    logic      pulse_req;
    logic      rst_q;

    assign pulse_req = wdt_pulse | sw_pulse | bod_req;

    rstseq_power_seq #(
        .INIT_CYC  (INIT_CYC),
        .START_LEN0(START_LEN0),
        .START_LEN1(START_LEN1),
        .START_LEN2(START_LEN2),
        .START_LEN3(START_LEN3),
        .CW        (CW)
    ) u_pseq (
        .clk     (clk),
        .por_ok  (por_ok),
        .dly_sel (dly_sel),
        .por_hold(hv.por_hold)
    );

    rstseq_pin_sync #(
        .STAGES(SYNC_STAGES)
    ) u_psync (
        .clk   (clk),
        .por_ok(por_ok),
        .pin_n (ext_rst_n),
        .active(hv.ext_hold)
    );

    rstseq_stretch #(
        .MIN_PULSE(MIN_PULSE),
        .PW       (PW)
    ) u_stretch (
        .clk   (clk),
        .por_ok(por_ok),
        .req   (pulse_req),
        .hold  (hv.pulse_hold)
    );

    rstseq_cold_flag u_cflag (
        .clk    (clk),
        .por_ok (por_ok),
        .wr_en  (cold_we),
        .wr_data(cold_wdata),
        .flag   (cold_flag)
    );

    // Assert without a clock on supply loss, release on a clock edge.
    always_ff @(posedge clk or negedge por_ok) begin
        if (!por_ok) begin
            rst_q <= 1'b1;
        end else begin
            rst_q <= hv.por_hold | hv.ext_hold | hv.pulse_hold;
        end
    end

    assign sys_rst    = rst_q;
    assign port_hiz   = rst_q;
    assign rst_vector = VEC_W'(RESET_VEC);

endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker #(
    parameter int INIT_CYC   = 8,
    parameter int START_LEN0 = 4
) (
    input logic clk,
    input logic por_ok,
    input logic bod_req,
    input logic ext_rst_n,
    input logic wdt_pulse,
    input logic sw_pulse,
    input logic cold_we,
    input logic cold_wdata,
    input logic sys_rst,
    input logic cold_flag
);
    localparam int LIM = INIT_CYC + START_LEN0 + 1;

    logic [15:0] since_up;

    always_ff @(posedge clk or negedge por_ok) begin
        if (!por_ok) begin
            since_up <= '0;
        end else if (since_up != 16'hFFFF) begin
            since_up <= since_up + 1'b1;
        end
    end

    // R4: never released before the shortest power-up sequence ends
    a_r4_por_hold: assert property (@(posedge clk) disable iff (!por_ok)
        (int'(since_up) < LIM) |-> sys_rst);

    // R6 / R7
    a_r6_pulse_reset: assert property (@(posedge clk) disable iff (!por_ok)
        (wdt_pulse || sw_pulse) |=> sys_rst);

    a_r8_bod_reset: assert property (@(posedge clk) disable iff (!por_ok)
        bod_req |=> sys_rst);

    // R9: release needs the pin seen high on the two previous edges
    a_r9_pin_release: assert property (@(posedge clk) disable iff (!por_ok)
        $fell(sys_rst) |-> ($past(ext_rst_n) && $past(ext_rst_n, 2)));

    a_r12_flag_clear: assert property (@(posedge clk) disable iff (!por_ok)
        (cold_we && !cold_wdata) |=> !cold_flag);

    a_r11_flag_kept: assert property (@(posedge clk) disable iff (!por_ok)
        !(cold_we && !cold_wdata) |=> $stable(cold_flag));

endmodule

bind rst_sequencer rstseq_checker #(
    .INIT_CYC  (INIT_CYC),
    .START_LEN0(START_LEN0)
) u_chk (
    .clk       (clk),
    .por_ok    (por_ok),
    .bod_req   (bod_req),
    .ext_rst_n (ext_rst_n),
    .wdt_pulse (wdt_pulse),
    .sw_pulse  (sw_pulse),
    .cold_we   (cold_we),
    .cold_wdata(cold_wdata),
    .sys_rst   (sys_rst),
    .cold_flag (cold_flag)
);

// File: tb/sim_rst_sequencer.sv
module sim_rst_sequencer;

    localparam int INIT_CYC  = 8;
    localparam int MIN_PULSE = 6;

    logic        clk = 1'b0;
    logic        por_ok, bod_req, ext_rst_n, wdt_pulse, sw_pulse;
    logic [1:0]  dly_sel;
    logic        cold_we, cold_wdata;
    logic        sys_rst, port_hiz, cold_flag;
    logic [15:0] rst_vector;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int    at;
        int    sig;
        logic  val;
        string req;
    } exp_item_t;

    exp_item_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rst_sequencer u0 (
        .clk       (clk),
        .por_ok    (por_ok),
        .bod_req   (bod_req),
        .ext_rst_n (ext_rst_n),
        .wdt_pulse (wdt_pulse),
        .sw_pulse  (sw_pulse),
        .dly_sel   (dly_sel),
        .cold_we   (cold_we),
        .cold_wdata(cold_wdata),
        .sys_rst   (sys_rst),
        .port_hiz  (port_hiz),
        .cold_flag (cold_flag),
        .rst_vector(rst_vector)
    );

    function automatic logic sig_val(input int s);
        case (s)
            0:       return sys_rst;
            1:       return port_hiz;
            default: return cold_flag;
        endcase
    endfunction

    function automatic string sig_name(input int s);
        case (s)
            0:       return "sys_rst";
            1:       return "port_hiz";
            default: return "cold_flag";
        endcase
    endfunction

    task automatic compare(input int s, input logic exp, input string req);
        logic act;
        act = sig_val(s);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d %s actual=%b expected=%b", req, cyc, sig_name(s), act, exp);
        end
    endtask

    task automatic expect_at(input int at, input int s, input logic v, input string req);
        exp_item_t it;
        it.at = at; it.sig = s; it.val = v; it.req = req;
        sb.push_back(it);
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: consume expected items due in this cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                compare(sb[i].sig, sb[i].val, sb[i].req);
                sb.delete(i);
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1..R12 run actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        int c;
        int d;
        por_ok = 1'b1; bod_req = 1'b0; ext_rst_n = 1'b1; wdt_pulse = 1'b0;
        sw_pulse = 1'b0; dly_sel = 2'b00; cold_we = 1'b0; cold_wdata = 1'b1;
        #1 por_ok = 1'b0;
        waitn(3);
        // reset state
        compare(0, 1'b1, "R1");
        compare(1, 1'b1, "R2");
        compare(2, 1'b1, "R11");
        checks++;
        if (rst_vector !== 16'h0000) begin
            errors++;
            $display("FAIL R3 rst_vector actual=%h expected=0000", rst_vector);
        end

        // R4 with shortest delay: release at edge 8+4+1
        c = cyc; por_ok = 1'b1;
        expect_at(c + 12, 0, 1'b1, "R4");
        expect_at(c + 13, 0, 1'b0, "R4");
        expect_at(c + 13, 1, 1'b0, "R2");
        waitn(16);

        // R12: write 1 keeps, write 0 clears
        cold_we = 1'b1; cold_wdata = 1'b1; c = cyc;
        expect_at(c + 1, 2, 1'b1, "R12");
        waitn(1);
        cold_wdata = 1'b0; c = cyc;
        expect_at(c + 1, 2, 1'b0, "R12");
        waitn(1);
        cold_we = 1'b0; cold_wdata = 1'b1;
        waitn(2);

        // R6: watchdog pulse
        compare(0, 1'b0, "R6");
        c = cyc; wdt_pulse = 1'b1;
        expect_at(c + 1, 0, 1'b1, "R6");
        expect_at(c + MIN_PULSE, 0, 1'b1, "R6");
        expect_at(c + MIN_PULSE + 1, 0, 1'b0, "R6");
        expect_at(c + MIN_PULSE + 1, 2, 1'b0, "R11");
        waitn(1); wdt_pulse = 1'b0;
        waitn(9);

        // R7: software strobe
        c = cyc; sw_pulse = 1'b1;
        expect_at(c + 1, 0, 1'b1, "R7");
        expect_at(c + MIN_PULSE, 0, 1'b1, "R7");
        expect_at(c + MIN_PULSE + 1, 0, 1'b0, "R7");
        expect_at(c + MIN_PULSE + 1, 2, 1'b0, "R11");
        waitn(1); sw_pulse = 1'b0;
        waitn(9);

        // R8: brown-out level for three edges
        c = cyc; bod_req = 1'b1;
        expect_at(c + 1, 0, 1'b1, "R8");
        expect_at(c + 3 + MIN_PULSE - 1, 0, 1'b1, "R8");
        expect_at(c + 3 + MIN_PULSE, 0, 1'b0, "R8");
        waitn(3); bod_req = 1'b0;
        waitn(9);

        // R9: external pin
        c = cyc; ext_rst_n = 1'b0;
        expect_at(c + 2, 0, 1'b0, "R9");
        expect_at(c + 3, 0, 1'b1, "R9");
        waitn(6);
        d = cyc; ext_rst_n = 1'b1;
        expect_at(d + 2, 0, 1'b1, "R9");
        expect_at(d + 3, 0, 1'b0, "R9");
        expect_at(d + 3, 2, 1'b0, "R11");
        waitn(6);

        // R1 / R5: supply loss, aborted sequence, restart with 16-cycle delay
        por_ok = 1'b0;
        #1;
        compare(0, 1'b1, "R1");
        compare(1, 1'b1, "R2");
        compare(2, 1'b1, "R11");
        waitn(2);
        por_ok = 1'b1;
        waitn(5);
        por_ok = 1'b0;
        waitn(2);
        dly_sel = 2'b10; c = cyc; por_ok = 1'b1;
        expect_at(c + INIT_CYC + 16, 0, 1'b1, "R5");
        expect_at(c + INIT_CYC + 17, 0, 1'b0, "R4");
        waitn(28);

        // R10: pin held low past the 8-cycle start-up delay
        por_ok = 1'b0; ext_rst_n = 1'b0; dly_sel = 2'b01;
        waitn(2);
        c = cyc; por_ok = 1'b1;
        expect_at(c + INIT_CYC + 9, 0, 1'b1, "R10");
        expect_at(c + 29, 0, 1'b1, "R10");
        waitn(30);
        d = cyc; ext_rst_n = 1'b1;
        expect_at(d + 2, 0, 1'b1, "R10");
        expect_at(d + 3, 0, 1'b0, "R10");
        waitn(6);

        // R4 with longest delay
        por_ok = 1'b0;
        waitn(2);
        dly_sel = 2'b11; c = cyc; por_ok = 1'b1;
        expect_at(c + INIT_CYC + 32, 0, 1'b1, "R4");
        expect_at(c + INIT_CYC + 33, 0, 1'b0, "R4");
        waitn(45);

        while (sb.size() != 0) waitn(1);
        done = 1;
        summary();
        $finish;
    end

endmodule